// File: doc/BRIEF.md
# Sprite Page Copy Engine

This engine copies one full page of main memory into a separate sprite attribute RAM with no CPU involvement. Software starts it by writing a page number to a one-byte trigger port. The engine then takes the main memory bus, reads the page one byte at a time, and writes each byte to the sprite RAM at the matching offset.

Reads and writes alternate on successive clock cycles. With the default 256-byte sprite RAM, a transfer lasts 512 cycles. A bus-hold output stays high for the whole transfer so that the CPU stalls. When the last byte has been written, the engine drops bus-hold and busy together.

The memory port is a plain strobe bus, not a valid/ready stream. The read strobe has no back-pressure, and read data must be valid in the same cycle as the strobe. The sprite RAM port has no back-pressure either: every write strobe is accepted.

Top module: `sprite_page_dma`

## Requirements
- R1: While reset is asserted and after reset is released, busy, bus_hold, mem_rd and spr_we are all 0 until a trigger write arrives.
- R2: A trigger write of page N is taken at a clock edge. In the next cycle busy is 1, mem_rd is 1 and mem_addr equals N × 256 (high byte N, low byte 0).
- R3: On the even cycles of a transfer (cycles 0, 2, 4, … counted from the first cycle after the trigger), mem_rd is 1 and spr_we is 0. The address of each read is one higher than the address of the previous read.
- R4: On the odd cycles of a transfer, spr_we is 1 and mem_rd is 0. spr_wdata is the byte sampled on mem_rdata in the cycle before. spr_addr starts at 0 and rises by one on each write.
- R5: A transfer lasts exactly 512 cycles. bus_hold is 1 in each of them and drops in the cycle after the write to sprite address 255.
- R6: When bus_hold is 0, neither mem_rd nor spr_we is asserted. busy follows bus_hold.
- R7: A trigger write during an active transfer restarts the transfer from the new page, with the sprite address back at 0 and a fresh 512-cycle bus hold.
- R8: Every page value works, including page 0xFF, whose reads run from 0xFF00 through 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_wr | input | 1 | Trigger write strobe |
| trig_page | input | 8 | Source page number |
| mem_addr | output | 16 | Main memory read address |
| mem_rd | output | 1 | Main memory read strobe |
| mem_rdata | input | 8 | Main memory read data, valid in the strobe cycle |
| bus_hold | output | 1 | Holds the main bus and stalls the CPU |
| spr_addr | output | 8 | Sprite RAM write address |
| spr_wdata | output | 8 | Sprite RAM write data |
| spr_we | output | 1 | Sprite RAM write enable |
| busy | output | 1 | Transfer in progress |

## Verification
The assertions check on every cycle the following properties:
- reads and writes never occur in the same cycle;
- no strobe is asserted while the bus is free;
- each read is followed by a write of the byte just read, unless a trigger restarts the transfer;
- the first read after a trigger lands on the right page;
- no bus hold runs past 512 cycles;
- a transfer ends just after the write to the last sprite address.

Only the bench scenarios can show that a whole page arrives in order, that the hold lasts exactly 512 cycles, that a restart discards the old page, and that the top page works.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
  typedef enum logic {
    PH_READ  = 1'b0,
    PH_WRITE = 1'b1
  } sdma_phase_e;
endpackage

// File: rtl/sdma_sequencer.sv
module sdma_sequencer
  import sdma_pkg::*;
#(
  parameter int PAGE_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output logic        active,
  output sdma_phase_e phase,
  output logic        last
);
  localparam int CNT_W = PAGE_W + 1;

  logic [CNT_W-1:0] step_q;
  logic             active_q;

  // Final step is 2*size-1, which is all ones in CNT_W bits.
  assign last   = active_q && (step_q == {CNT_W{1'b1}});
  assign phase  = step_q[0] ? PH_WRITE : PH_READ;
  assign active = active_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      step_q   <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      step_q   <= '0;
    end else if (active_q) begin
      step_q <= step_q + 1'b1;
      if (last) begin
        active_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sdma_addr_gen.sv
module sdma_addr_gen #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [ADDR_W-PAGE_W-1:0] page,
  input  logic                     rd_step,
  input  logic                     wr_step,
  output logic [ADDR_W-1:0]        src_addr,
  output logic [PAGE_W-1:0]        dst_addr
);
  logic [ADDR_W-1:0] src_q;
  logic [PAGE_W-1:0] dst_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
    end else if (start) begin
      src_q <= {page, {PAGE_W{1'b0}}};
      dst_q <= '0;
    end else begin
      if (rd_step) src_q <= src_q + 1'b1;
      if (wr_step) dst_q <= dst_q + 1'b1;
    end
  end

  assign src_addr = src_q;
  assign dst_addr = dst_q;
endmodule

// File: rtl/sdma_data_latch.sv
module sdma_data_latch #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout <= '0;
    end else if (load) begin
      dout <= din;
    end
  end
endmodule

// File: rtl/sprite_page_dma.sv
module sprite_page_dma
  import sdma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 8,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     trig_wr,
  input  logic [ADDR_W-PAGE_W-1:0] trig_page,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic                     mem_rd,
  input  logic [DATA_W-1:0]        mem_rdata,
  output logic                     bus_hold,
  output logic [PAGE_W-1:0]        spr_addr,
  output logic [DATA_W-1:0]        spr_wdata,
  output logic                     spr_we,
  output logic                     busy
);
  logic        active;
  logic        last;
  sdma_phase_e phase;
  logic        rd_now;
  logic        wr_now;

  sdma_sequencer #(.PAGE_W(PAGE_W)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (trig_wr),
    .active (active),
    .phase  (phase),
    .last   (last)
  );

  assign rd_now = active && (phase == PH_READ);
  assign wr_now = active && (phase == PH_WRITE);

  sdma_addr_gen #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (trig_wr),
    .page     (trig_page),
    .rd_step  (rd_now),
    .wr_step  (wr_now),
    .src_addr (mem_addr),
    .dst_addr (spr_addr)
  );

  sdma_data_latch #(.DATA_W(DATA_W)) u_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (rd_now),
    .din   (mem_rdata),
    .dout  (spr_wdata)
  );

  assign mem_rd   = rd_now;
  assign spr_we   = wr_now;
  assign bus_hold = active;
  assign busy     = active;
endmodule

// File: rtl/sprite_page_dma_chk.sv
module sprite_page_dma_chk #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 8,
  parameter int DATA_W = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     trig_wr,
  input logic [ADDR_W-PAGE_W-1:0] trig_page,
  input logic [ADDR_W-1:0]        mem_addr,
  input logic                     mem_rd,
  input logic [DATA_W-1:0]        mem_rdata,
  input logic                     bus_hold,
  input logic [PAGE_W-1:0]        spr_addr,
  input logic [DATA_W-1:0]        spr_wdata,
  input logic                     spr_we,
  input logic                     busy
);
  localparam int RUN_W   = PAGE_W + 2;
  localparam int MAX_RUN = 2 * (1 << PAGE_W);

  logic [RUN_W-1:0] hold_run;

  always_ff @(posedge clk) begin
    if (!rst_n)        hold_run <= '0;
    else if (trig_wr)  hold_run <= RUN_W'(1);
    else if (bus_hold) hold_run <= hold_run + 1'b1;
    else               hold_run <= '0;
  end

  p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && spr_we));

  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_hold |-> (!mem_rd && !spr_we && !busy));

  p_read_then_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !trig_wr) |=> spr_we);

  p_write_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (spr_we && $past(mem_rd)) |-> (spr_wdata == $past(mem_rdata)));

  p_start_page_r2: assert property (@(posedge clk) disable iff (!rst_n)
    trig_wr |=> (busy && mem_rd && mem_addr[PAGE_W-1:0] == '0
                 && mem_addr[ADDR_W-1:PAGE_W] == $past(trig_page)));

  p_hold_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_hold |-> (hold_run <= RUN_W'(MAX_RUN)));

  p_end_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_hold) |-> ($past(spr_we) && $past(spr_addr) == {PAGE_W{1'b1}}));
endmodule

bind sprite_page_dma sprite_page_dma_chk #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/sprite_page_dma_test.sv
`timescale 1ns/1ps
module sprite_page_dma_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig_wr = 1'b0;
  logic [7:0]  trig_page = 8'h00;
  logic [15:0] mem_addr;
  logic        mem_rd;
  logic [7:0]  mem_rdata;
  logic        bus_hold;
  logic [7:0]  spr_addr;
  logic [7:0]  spr_wdata;
  logic        spr_we;
  logic        busy;

  int n_checks = 0;
  int n_errors = 0;
  logic [7:0] seed = 8'h00;
  logic [7:0] cur_page = 8'h00;

  int hold_cnt, rd_idx, wr_idx, addr_err, data_err, both_err;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] mem_fn(input logic [15:0] a, input logic [7:0] s);
    return (a[7:0] * 8'd3) ^ a[15:8] ^ s;
  endfunction

  assign mem_rdata = mem_fn(mem_addr, seed);

  sprite_page_dma uut (
    .clk(clk), .rst_n(rst_n), .trig_wr(trig_wr), .trig_page(trig_page),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
    .bus_hold(bus_hold), .spr_addr(spr_addr), .spr_wdata(spr_wdata),
    .spr_we(spr_we), .busy(busy)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    hold_cnt = 0; rd_idx = 0; wr_idx = 0;
    addr_err = 0; data_err = 0; both_err = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_hold) hold_cnt++;
      if (mem_rd && spr_we) both_err++;
      if (mem_rd) begin
        if (mem_addr != {cur_page, 8'h00} + 16'(rd_idx)) addr_err++;
        rd_idx++;
      end
      if (spr_we) begin
        if (spr_addr != 8'(wr_idx)) addr_err++;
        if (spr_wdata != mem_fn({cur_page, 8'(wr_idx)}, seed)) data_err++;
        wr_idx++;
      end
    end
  end

  task automatic trigger(input logic [7:0] pg);
    @(posedge clk); #1;
    trig_wr = 1'b1; trig_page = pg;
    @(posedge clk); #1;
    trig_wr = 1'b0;
    cur_page = pg;
    clear_mon();
  endtask

  task automatic wait_done();
    for (int i = 0; i < 1200 && busy; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_run(input string tag);
    chk(hold_cnt == 512, {tag, " R5 hold length"}, hold_cnt, 512);
    chk(wr_idx == 256 && rd_idx == 256, {tag, " R4 byte count"}, wr_idx, 256);
    chk(addr_err == 0, {tag, " R3 address order"}, addr_err, 0);
    chk(data_err == 0, {tag, " R4 sprite data"}, data_err, 0);
    chk(both_err == 0, {tag, " R6 no overlap"}, both_err, 0);
    chk(!busy && !bus_hold, {tag, " R6 released"}, {busy, bus_hold}, 0);
  endtask

  // page, seed
  localparam logic [15:0] VEC [4] = '{16'h0300, 16'h12A5, 16'h805A, 16'hFF3C};

  initial begin
    #300000;
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    clear_mon();
    repeat (3) @(negedge clk);
    chk(!busy && !bus_hold && !mem_rd && !spr_we, "R1 in reset",
        {busy, bus_hold, mem_rd, spr_we}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !bus_hold && !mem_rd && !spr_we, "R1 after reset",
        {busy, bus_hold, mem_rd, spr_we}, 0);

    // Directed first-cycle checks
    seed = 8'h11;
    trigger(8'h42);
    @(negedge clk);
    chk(busy && mem_rd && !spr_we, "R2 first read", {busy, mem_rd, spr_we}, 3'b110);
    chk(mem_addr == 16'h4200, "R2 start address", mem_addr, 16'h4200);
    @(negedge clk);
    chk(spr_we && !mem_rd && spr_addr == 8'h00, "R4 first write",
        {spr_we, mem_rd, spr_addr}, 10'h200);
    chk(spr_wdata == mem_fn(16'h4200, 8'h11), "R4 first data", spr_wdata,
        mem_fn(16'h4200, 8'h11));
    @(negedge clk);
    chk(mem_rd && mem_addr == 16'h4201, "R3 second read", mem_addr, 16'h4201);
    wait_done();

    // Table-driven transfers, R8 covered by page FF
    foreach (VEC[k]) begin
      seed = VEC[k][7:0];
      trigger(VEC[k][15:8]);
      wait_done();
      check_run($sformatf("vec%0d R8", k));
    end

    // Restart during transfer (R7)
    seed = 8'h77;
    trigger(8'h10);
    repeat (101) @(negedge clk);
    trigger(8'h20);
    wait_done();
    check_run("R7 restart");

    // Idle after completion (R6)
    repeat (5) @(negedge clk);
    chk(!mem_rd && !spr_we && !bus_hold, "R6 idle quiet",
        {mem_rd, spr_we, bus_hold}, 0);

    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule